// File: doc/BRIEF.md
# Hybrid Weighted-Slot LED Matrix Scan Controller

This block refreshes one HUB75-style LED panel chain whose pixels live in an external frame buffer. Every color channel of every pixel is an intensity code. For each row address the controller shows the code one bit plane at a time. The low bits are shown as binary-weighted output-enable pulses, each inside a slot of fixed length. The two top bits are shown as several repeated slots with a full-length pulse each: the second-highest bit gets two slots and the highest bit gets four. With the default parameters this gives 11-bit codes, 256-count slots and 15 planes per row.

While one plane is on the LEDs, the block reads the next plane's pixels from the buffer and shifts them into the panel. The panel shift clock is the gated combination of a half-rate pixel clock and a data-enable, so it pulses only for real data. A blanking gap follows the display window of each slot. During that gap the latch is strobed and the row address moves, with output enable held off on both sides. A global brightness value scales every pulse width. A frame-start pulse marks the latch that begins row 0.

Top module: `ledscan_ctrl`

## Requirements
- R1: In the first cycle after synchronous reset is released, oe_n is 1 and lat, sclk, row_addr and frame_start are 0.
- R2: With L = SLOT_BITS+1 and a code width of L+2 bits, a row uses L+6 planes in this order. Plane p for p < L shows code bit p. The next 2 planes show bit L, and the last 4 planes show bit L+1. Then plane 0 of the following row comes.
- R3: With slot length S = 2^SLOT_BITS, plane p < L has weight 2^p and every later plane has weight S. The number of cycles with oe_n low after a latch, until the next latch, is (weight*(bright+1)) >> BRIGHT_BITS.
- R4: While bright is 0, oe_n stays 1 in every cycle.
- R5: Between two latches, exactly COLS sclk pulses occur, carrying columns 0 to COLS-1 in order. The read port asserts rd_en with rd_row and rd_col, and the buffer returns rd_top and rd_bot on the next cycle, each packed as {R,G,B} with CODE bits per channel. At each pulse, rgb_top and rgb_bot bits 2, 1 and 0 carry the R, G and B code bits that R2 selects for the plane being latched next.
- R6: sclk is high for single cycles only, and rgb_top and rgb_bot do not change in a cycle where sclk is high.
- R7: oe_n is 1 in the cycle before lat, the cycle of lat and the cycle after it. row_addr changes only in a cycle where lat is 1.
- R8: row_addr takes the new row at the latch of plane 0. It counts from 0 to 2^ROW_BITS-1 and wraps to 0.
- R9: frame_start is 1 for exactly the cycles where lat loads plane 0 of row 0. This includes the first latch after reset.
- R10: With every code at its maximum and bright at its maximum, the oe_n low cycles in one row total 2^L-1 + 6*S.
- R11: Before the first latch after reset, oe_n stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bright | input | BRIGHT_BITS | Global brightness, 0 = dark |
| rd_en | output | 1 | Pixel read request |
| rd_row | output | ROW_BITS | Row of the requested pixel pair |
| rd_col | output | COL_W | Column of the requested pixel pair |
| rd_top | input | 3*CODE | Upper half-panel pixel {R,G,B}, one cycle after rd_en |
| rd_bot | input | 3*CODE | Lower half-panel pixel {R,G,B}, one cycle after rd_en |
| rgb_top | output | 3 | Upper half data bits R,G,B |
| rgb_bot | output | 3 | Lower half data bits R,G,B |
| sclk | output | 1 | Gated panel shift clock |
| lat | output | 1 | Latch strobe |
| oe_n | output | 1 | Output enable, active low |
| row_addr | output | ROW_BITS | Row address lines |
| frame_start | output | 1 | Pulse at the latch of row 0, plane 0 |

## Verification
The hardest overlap is a plane being shown while the next plane is shifted in. sclk pulses and reads take place inside the very window where oe_n is low for the current plane. The full-width upper-bit planes hold oe_n low for the whole slot, so every shift pulse lands inside an active pulse. The bench provokes this with patterned, all-maximum and scaled-brightness codes. At every latch it compares the captured shift bits against the plane being latched. It then counts the oe_n low cycles of the following interval against the weight of the plane that is displayed, so a mix-up between the two planes shows in one of the two comparisons.

// File: rtl/ledscan_pkg.sv
package ledscan_pkg;

    typedef enum logic {
        PH_DISP  = 1'b0,
        PH_BLANK = 1'b1
    } scan_phase_t;

    typedef struct packed {
        logic r;
        logic g;
        logic b;
    } rgb_t;

    // Code bit shown by a plane; low = number of binary-weighted planes.
    function automatic int plane_bit(input int p, input int low);
        if (p < low)
            return p;
        else if (p < low + 2)
            return low;
        else
            return low + 1;
    endfunction

    // Pulse weight of a plane in slot counts.
    function automatic int plane_weight(input int p, input int low, input int slot);
        if (p < low)
            return 1 << p;
        else
            return slot;
    endfunction

endpackage

// File: rtl/ledscan_pulse.sv
module ledscan_pulse
    import ledscan_pkg::*;
#(
    parameter int SLOT_BITS   = 8,
    parameter int BRIGHT_BITS = 8,
    parameter int PL_W        = 4
) (
    input  logic [PL_W-1:0]        plane,
    input  logic [BRIGHT_BITS-1:0] bright,
    output logic [SLOT_BITS:0]     width
);
    localparam int LOW   = SLOT_BITS + 1;
    localparam int SLOT  = 1 << SLOT_BITS;
    localparam int PROD_W = SLOT_BITS + BRIGHT_BITS + 2;

    logic [SLOT_BITS:0]   weight;
    logic [BRIGHT_BITS:0] scale;
    logic [PROD_W-1:0]    prod;

    always_comb begin
        weight = (SLOT_BITS+1)'(plane_weight(int'(plane), LOW, SLOT));
        scale  = {1'b0, bright} + (BRIGHT_BITS+1)'(1);
        prod   = PROD_W'(weight) * PROD_W'(scale);
        if (bright == '0)
            width = '0;
        else
            width = (SLOT_BITS+1)'(prod >> BRIGHT_BITS);
    end

endmodule

// File: rtl/ledscan_seq.sv
module ledscan_seq
    import ledscan_pkg::*;
#(
    parameter int ROW_BITS  = 5,
    parameter int SLOT_BITS = 8,
    parameter int PL_W      = 4,
    parameter int PLANES    = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SLOT_BITS:0]   width,
    output logic [PL_W-1:0]      disp_pl,
    output logic [ROW_BITS-1:0]  nxt_row,
    output logic [PL_W-1:0]      nxt_pl,
    output scan_phase_t          ph,
    output logic [SLOT_BITS-1:0] cnt,
    output logic                 oe_n,
    output logic                 lat,
    output logic [ROW_BITS-1:0]  row_addr,
    output logic                 frame_start
);
    localparam logic [PL_W-1:0] LAST_PL = PL_W'(PLANES - 1);

    logic [ROW_BITS-1:0] cur_row;
    logic [PL_W-1:0]     cur_pl;
    logic                cur_valid;
    logic [1:0]          bcnt;
    logic                latch_now;
    logic                oe_on;

    // successor of the displayed plane: the one being shifted
    always_comb begin
        if (cur_pl == LAST_PL) begin
            nxt_pl  = '0;
            nxt_row = cur_row + ROW_BITS'(1);
        end else begin
            nxt_pl  = cur_pl + PL_W'(1);
            nxt_row = cur_row;
        end
        latch_now = (ph == PH_BLANK) && (bcnt == 2'd1);
        oe_on     = (ph == PH_DISP) && cur_valid && ({1'b0, cnt} < width);
    end

    assign disp_pl = cur_pl;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph          <= PH_DISP;
            cnt         <= '0;
            bcnt        <= '0;
            cur_row     <= '1;
            cur_pl      <= LAST_PL;
            cur_valid   <= 1'b0;
            oe_n        <= 1'b1;
            lat         <= 1'b0;
            row_addr    <= '0;
            frame_start <= 1'b0;
        end else begin
            oe_n        <= !oe_on;
            lat         <= latch_now;
            frame_start <= latch_now && (nxt_row == '0) && (nxt_pl == '0);
            case (ph)
                PH_DISP: begin
                    if (cnt == '1) begin
                        ph   <= PH_BLANK;
                        bcnt <= '0;
                    end
                    cnt <= cnt + SLOT_BITS'(1);
                end
                default: begin
                    bcnt <= bcnt + 2'd1;
                    if (latch_now) begin
                        cur_row   <= nxt_row;
                        cur_pl    <= nxt_pl;
                        cur_valid <= 1'b1;
                        row_addr  <= nxt_row;
                    end
                    if (bcnt == 2'd2) begin
                        ph  <= PH_DISP;
                        cnt <= '0;
                    end
                end
            endcase
        end
    end

    AST_LAT_OE_OFF: assert property (@(posedge clk) disable iff (rst)
        lat |-> (oe_n && $past(oe_n)));                                 // R7
    AST_OE_OFF_AFTER_LAT: assert property (@(posedge clk) disable iff (rst)
        lat |=> oe_n);                                                  // R7
    AST_ADDR_AT_LAT: assert property (@(posedge clk) disable iff (rst)
        (row_addr != $past(row_addr)) |-> lat);                         // R7
    AST_FS_WITH_LAT: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (lat && row_addr == '0));                       // R9

endmodule

// File: rtl/ledscan_shift.sv
module ledscan_shift
    import ledscan_pkg::*;
#(
    parameter int ROW_BITS  = 5,
    parameter int SLOT_BITS = 8,
    parameter int COLS      = 64,
    parameter int CODE      = 11,
    parameter int PL_W      = 4,
    parameter int COL_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  scan_phase_t          ph,
    input  logic [SLOT_BITS-1:0] cnt,
    input  logic [ROW_BITS-1:0]  nxt_row,
    input  logic [PL_W-1:0]      nxt_pl,
    output logic                 rd_en,
    output logic [ROW_BITS-1:0]  rd_row,
    output logic [COL_W-1:0]     rd_col,
    input  logic [3*CODE-1:0]    rd_top,
    input  logic [3*CODE-1:0]    rd_bot,
    output rgb_t                 rgb_top,
    output rgb_t                 rgb_bot,
    output logic                 sclk
);
    localparam int LOW   = SLOT_BITS + 1;
    localparam int BIT_W = $clog2(CODE);

    logic [SLOT_BITS-1:0] half_cnt;
    logic [BIT_W-1:0]     bit_idx;
    logic                 data_vld;
    logic                 den;
    logic [2:0]           top_bits;
    logic [2:0]           bot_bits;

    always_comb begin
        half_cnt = cnt >> 1;
        rd_en    = (ph == PH_DISP) && !cnt[0] && (half_cnt < SLOT_BITS'(COLS));
        rd_col   = COL_W'(half_cnt);
        rd_row   = nxt_row;
        bit_idx  = BIT_W'(plane_bit(int'(nxt_pl), LOW));
    end

    // channel 2 = R, 1 = G, 0 = B in both the buffer word and the outputs
    for (genvar ch = 0; ch < 3; ch++) begin : g_chan
        logic [CODE-1:0] top_code;
        logic [CODE-1:0] bot_code;
        assign top_code     = rd_top[ch*CODE +: CODE];
        assign bot_code     = rd_bot[ch*CODE +: CODE];
        assign top_bits[ch] = top_code[bit_idx];
        assign bot_bits[ch] = bot_code[bit_idx];
    end

    // half-rate pixel clock: data on one cycle, clock high the next
    always_ff @(posedge clk) begin
        if (rst) begin
            data_vld <= 1'b0;
            den      <= 1'b0;
            sclk     <= 1'b0;
            rgb_top  <= '0;
            rgb_bot  <= '0;
        end else begin
            data_vld <= rd_en;
            if (data_vld) begin
                rgb_top <= top_bits;
                rgb_bot <= bot_bits;
                den     <= 1'b1;
                sclk    <= 1'b0;
            end else begin
                sclk <= den;
                den  <= 1'b0;
            end
        end
    end

    AST_SCLK_PULSE: assert property (@(posedge clk) disable iff (rst)
        sclk |=> !sclk);                                                // R6
    AST_SCLK_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        sclk |-> ($stable(rgb_top) && $stable(rgb_bot)));              // R6
    AST_SCLK_IN_DISPLAY: assert property (@(posedge clk) disable iff (rst)
        sclk |-> (ph == PH_DISP));                                      // R5

endmodule

// File: rtl/ledscan_ctrl.sv
module ledscan_ctrl
    import ledscan_pkg::*;
#(
    parameter int ROW_BITS    = 5,
    parameter int SLOT_BITS   = 8,
    parameter int COLS        = 64,
    parameter int BRIGHT_BITS = 8,
    localparam int CODE       = SLOT_BITS + 3,
    localparam int PLANES     = SLOT_BITS + 7,
    localparam int PL_W       = $clog2(PLANES),
    localparam int COL_W      = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [BRIGHT_BITS-1:0] bright,
    output logic                   rd_en,
    output logic [ROW_BITS-1:0]    rd_row,
    output logic [COL_W-1:0]       rd_col,
    input  logic [3*CODE-1:0]      rd_top,
    input  logic [3*CODE-1:0]      rd_bot,
    output logic [2:0]             rgb_top,
    output logic [2:0]             rgb_bot,
    output logic                   sclk,
    output logic                   lat,
    output logic                   oe_n,
    output logic [ROW_BITS-1:0]    row_addr,
    output logic                   frame_start
);
    logic [PL_W-1:0]      disp_pl;
    logic [PL_W-1:0]      nxt_pl;
    logic [ROW_BITS-1:0]  nxt_row;
    logic [SLOT_BITS:0]   width;
    logic [SLOT_BITS-1:0] cnt;
    scan_phase_t          ph;
    rgb_t                 top_q;
    rgb_t                 bot_q;

    ledscan_pulse #(
        .SLOT_BITS(SLOT_BITS), .BRIGHT_BITS(BRIGHT_BITS), .PL_W(PL_W)
    ) u_pulse (
        .plane(disp_pl), .bright(bright), .width(width)
    );

    ledscan_seq #(
        .ROW_BITS(ROW_BITS), .SLOT_BITS(SLOT_BITS), .PL_W(PL_W), .PLANES(PLANES)
    ) u_seq (
        .clk(clk), .rst(rst), .width(width), .disp_pl(disp_pl),
        .nxt_row(nxt_row), .nxt_pl(nxt_pl), .ph(ph), .cnt(cnt),
        .oe_n(oe_n), .lat(lat), .row_addr(row_addr), .frame_start(frame_start)
    );

    ledscan_shift #(
        .ROW_BITS(ROW_BITS), .SLOT_BITS(SLOT_BITS), .COLS(COLS),
        .CODE(CODE), .PL_W(PL_W), .COL_W(COL_W)
    ) u_shift (
        .clk(clk), .rst(rst), .ph(ph), .cnt(cnt), .nxt_row(nxt_row),
        .nxt_pl(nxt_pl), .rd_en(rd_en), .rd_row(rd_row), .rd_col(rd_col),
        .rd_top(rd_top), .rd_bot(rd_bot), .rgb_top(top_q), .rgb_bot(bot_q),
        .sclk(sclk)
    );

    assign rgb_top = top_q;
    assign rgb_bot = bot_q;

    AST_DARK: assert property (@(posedge clk) disable iff (rst)
        (bright == '0) |=> oe_n);                                       // R4

endmodule

// File: tb/tb_ledscan_ctrl.sv
module tb_ledscan_ctrl;
    localparam int COLS   = 4;
    localparam int RB     = 2;
    localparam int SB     = 4;
    localparam int BB     = 4;
    localparam int CODE   = SB + 3;
    localparam int LOW    = SB + 1;
    localparam int PLANES = LOW + 6;
    localparam int SLOT   = 1 << SB;
    localparam int ROWS   = 1 << RB;
    localparam int CW     = 2;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [BB-1:0]       bright = '0;
    logic                rd_en;
    logic [RB-1:0]       rd_row;
    logic [CW-1:0]       rd_col;
    logic [3*CODE-1:0]   rd_top = '0;
    logic [3*CODE-1:0]   rd_bot = '0;
    logic [2:0]          rgb_top, rgb_bot;
    logic                sclk, lat, oe_n, frame_start;
    logic [RB-1:0]       row_addr;

    int checks = 0;
    int fails  = 0;
    int mode   = 0;
    int seed   = 0;
    bit done   = 0;

    ledscan_ctrl #(.ROW_BITS(RB), .SLOT_BITS(SB), .COLS(COLS), .BRIGHT_BITS(BB)) dut (
        .clk(clk), .rst(rst), .bright(bright), .rd_en(rd_en), .rd_row(rd_row),
        .rd_col(rd_col), .rd_top(rd_top), .rd_bot(rd_bot), .rgb_top(rgb_top),
        .rgb_bot(rgb_bot), .sclk(sclk), .lat(lat), .oe_n(oe_n),
        .row_addr(row_addr), .frame_start(frame_start)
    );

    always #10 clk = ~clk;

    function automatic logic [CODE-1:0] pix(int md, int sd, int row, int col, int ch, int half);
        if (md == 1) return '1;
        if (md == 2) return '0;
        return CODE'(sd * 37 + row * 11 + col * 5 + ch * 3 + half * 7 + row * col * 13);
    endfunction

    function automatic int exp_bit(int p);
        if (p < LOW) return p;
        if (p < LOW + 2) return LOW;
        return LOW + 1;
    endfunction

    function automatic int exp_width(int p, int b);
        int w;
        w = (p < LOW) ? (1 << p) : SLOT;
        if (b == 0) return 0;
        return (w * (b + 1)) >> BB;
    endfunction

    // external buffer with one cycle read latency
    always @(posedge clk) begin
        if (rd_en) begin
            for (int ch = 0; ch < 3; ch++) begin
                rd_top[ch*CODE +: CODE] <= pix(mode, seed, int'(rd_row), int'(rd_col), ch, 0);
                rd_bot[ch*CODE +: CODE] <= pix(mode, seed, int'(rd_row), int'(rd_col), ch, 1);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // monitor state
    bit         mon_en = 0;
    int         lat_cnt, exp_row, exp_pl, cap_n, oe_cnt, cur_w, row_tot, last_row_tot;
    int         fs_cnt, tot_oe;
    bit         had_valid, prev_oe, prev_lat;
    logic [RB-1:0] prev_addr;
    logic [2:0] cap_top [COLS];
    logic [2:0] cap_bot [COLS];

    task automatic mon_clear();
        lat_cnt = 0; exp_row = 0; exp_pl = 0; cap_n = 0; oe_cnt = 0; cur_w = 0;
        row_tot = 0; last_row_tot = -1; fs_cnt = 0; tot_oe = 0;
        had_valid = 0; prev_oe = 1; prev_lat = 0; prev_addr = '0;
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            logic [3*COLS-1:0] act_t, act_b, exp_t, exp_b;
            if (sclk) begin
                if (cap_n < COLS) begin
                    cap_top[cap_n] = rgb_top;
                    cap_bot[cap_n] = rgb_bot;
                end
                cap_n++;
            end
            if (!oe_n) begin
                oe_cnt++; row_tot++; tot_oe++;
            end
            if (prev_lat)
                check(oe_n == 1'b1, "R7 oe after latch", int'(oe_n), 1);
            if (frame_start && !lat)
                check(1'b0, "R9 frame_start without latch", 1, 0);
            if (!lat && row_addr != prev_addr)
                check(1'b0, "R7 row change outside latch", int'(row_addr), int'(prev_addr));
            if (lat) begin
                check(oe_n && prev_oe, "R7 oe around latch", int'(oe_n && prev_oe), 1);
                check(cap_n == COLS, "R5 pulses per plane", cap_n, COLS);
                for (int c = 0; c < COLS; c++) begin
                    for (int ch = 0; ch < 3; ch++) begin
                        exp_t[c*3+ch] = pix(mode, seed, exp_row, c, ch, 0)[exp_bit(exp_pl)];
                        exp_b[c*3+ch] = pix(mode, seed, exp_row, c, ch, 1)[exp_bit(exp_pl)];
                    end
                    act_t[c*3 +: 3] = cap_top[c];
                    act_b[c*3 +: 3] = cap_bot[c];
                end
                check(act_t == exp_t && act_b == exp_b, "R2 R5 shifted plane bits",
                      int'({act_t, act_b}), int'({exp_t, exp_b}));
                check(row_addr == RB'(exp_row), "R8 row address", int'(row_addr), exp_row);
                check(frame_start == (exp_row == 0 && exp_pl == 0), "R9 frame_start at latch",
                      int'(frame_start), int'(exp_row == 0 && exp_pl == 0));
                if (had_valid)
                    check(oe_cnt == cur_w, "R3 oe pulse width", oe_cnt, cur_w);
                else
                    check(oe_cnt == 0, "R11 dark before first latch", oe_cnt, 0);
                if (frame_start) fs_cnt++;
                if (exp_pl == 0) begin
                    last_row_tot = row_tot;
                    row_tot = 0;
                end
                cur_w = exp_width(exp_pl, int'(bright));
                had_valid = 1;
                lat_cnt++;
                cap_n = 0;
                oe_cnt = 0;
                if (exp_pl == PLANES - 1) begin
                    exp_pl = 0;
                    exp_row = (exp_row + 1) % ROWS;
                end else begin
                    exp_pl++;
                end
            end
            prev_oe   = oe_n;
            prev_lat  = lat;
            prev_addr = row_addr;
        end
    end

    task automatic start(input int md, input int sd, input int b);
        mon_en = 0;
        @(negedge clk);
        rst = 1; mode = md; seed = sd; bright = BB'(b);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        mon_clear();
        mon_en = 1;
    endtask

    task automatic wait_latches(input int n);
        int guard = 0;
        while (lat_cnt < n && guard < 40000) begin
            @(negedge clk);
            guard++;
        end
        check(lat_cnt >= n, "R8 latch progress", lat_cnt, n);
    endtask

    task automatic t_reset();
        mon_en = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(oe_n == 1'b1, "R1 oe_n", int'(oe_n), 1);
        check(lat == 1'b0, "R1 lat", int'(lat), 0);
        check(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
        check(row_addr == '0, "R1 row_addr", int'(row_addr), 0);
        check(frame_start == 1'b0, "R1 frame_start", int'(frame_start), 0);
    endtask

    task automatic t_pattern_full();
        start(0, 3, (1 << BB) - 1);
        wait_latches(2 * ROWS * PLANES + 1);
        check(fs_cnt == 3, "R9 frame_start count", fs_cnt, 3);
    endtask

    task automatic t_pattern_odd_bright();
        start(0, 9, 10);
        wait_latches(ROWS * PLANES + 2);
    endtask

    task automatic t_half_bright();
        start(0, 21, 7);
        wait_latches(ROWS * PLANES + 2);
    endtask

    task automatic t_full_duty();
        start(1, 0, (1 << BB) - 1);
        wait_latches(2 * PLANES + 1);
        check(last_row_tot == (1 << LOW) - 1 + 6 * SLOT, "R10 row on-time",
              last_row_tot, (1 << LOW) - 1 + 6 * SLOT);
    endtask

    task automatic t_dark();
        start(1, 0, 0);
        wait_latches(PLANES + 3);
        check(tot_oe == 0, "R4 dark with zero brightness", tot_oe, 0);
    endtask

    task automatic t_zero_codes();
        start(2, 0, (1 << BB) - 1);
        wait_latches(PLANES + 2);
    endtask

    initial begin
        t_reset();
        t_pattern_full();
        t_pattern_odd_bright();
        t_half_bright();
        t_full_duty();
        t_dark();
        t_zero_codes();
        mon_en = 0;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule